// File: doc/BRIEF.md
# Unlock-Sequence Flash Command Decoder

This block sits behind the asynchronous control pins of a byte-wide flash memory and turns bus write cycles into decoded commands. A front stage samples the active-low chip enable, write enable and output enable pins on the system clock and forms one write event per bus write. The address is taken when the write window opens. The data is taken on the last clock of the window. A sequencing stage then matches these events against the keyed command patterns. It emits a one-cycle command pulse that carries an operation code, the captured address and data, and the sector index.

Every command except the lone reset byte is guarded by a fixed pair of unlock writes. Erase commands need a second unlock pair after their setup byte. A write that does not fit the expected step is dropped, and the sequence returns to its first step without a command. A supply-fault input freezes the decoder in read mode while it is high. The program and erase engines that act on the pulses lie outside this block. The engine reports a running sector erase back through a level input, so that suspend and resume bytes can be accepted.

The command output has no back-pressure. A pulse lasts exactly one clock and must be taken in that cycle. The pins are control inputs and carry no handshake. Write events cannot arrive faster than one every two clocks, so no queue is needed.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the decoder is in read mode with `cmd_valid` low, and a full program sequence is accepted with no preceding reset command.
- R2: A write takes place only while `ce_n` and `we_n` are both low and `oe_n` is high. A window during which `oe_n` falls is discarded, and no write occurs while `oe_n` is low or `ce_n` is high.
- R3: The address is taken on the first clock of the write window. The data is the value on the last clock before `ce_n` or `we_n` rises.
- R4: The unlock pair is AAh written to 5555h, followed by 55h written to 2AAAh. Only address bits 14..0 are compared, so bits 18..15 may hold any value.
- R5: The third write must go to 5555h. Writing 90h there emits autoselect (op 1). Writing A0h there enters program setup, and 80h enters erase setup; neither emits a pulse. Op codes are: 0 read/reset, 1 autoselect, 2 program, 3 chip erase, 4 sector erase, 5 suspend, 6 resume.
- R6: After program setup, the next write of any address and data emits op 2 carrying that address and data, including a data value of F0h.
- R7: After erase setup, a second unlock pair followed by 10h at 5555h emits op 3. Writing 10h to any other address emits nothing.
- R8: After erase setup and a second unlock pair, 30h at any address emits op 4. `cmd_sector` carries address bits 18..16.
- R9: Writing F0h to any address, in any step except the program data step, emits op 0 and returns the decoder to the first step.
- R10: While `erase_active` is high and the decoder is at its first step, B0h at any address emits op 5 and 30h at any address emits op 6. While `erase_active` is low, these bytes emit nothing.
- R11: A write that does not match the expected step returns the decoder to the first step and emits nothing. That write is not reused as a first unlock write.
- R12: While `inhibit` is high, writes are ignored, no command is emitted, and the sequence is forced back to its first step.
- R13: If `ce_n` and `we_n` are already low when reset is released, no write is recognised until one of them has been seen high.
- R14: `cmd_valid` is high for exactly one clock. It rises on the second clock edge at which `ce_n` or `we_n` is first sampled high after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low, already synchronised |
| we_n | input | 1 | Write enable, active low, already synchronised |
| oe_n | input | 1 | Output enable, active low, already synchronised |
| addr | input | ADDR_W (19) | Bus address |
| data_in | input | 8 | Bus write data |
| inhibit | input | 1 | Supply-fault lockout, high blocks writes |
| erase_active | input | 1 | High while a sector erase is running |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_op | output | 3 | Operation code, see R5 |
| cmd_addr | output | ADDR_W (19) | Address of the write that completed the command |
| cmd_data | output | 8 | Data of the write that completed the command |
| cmd_sector | output | SECT_W (3) | Upper address bits of that write |

## Verification
A wrong sequence step stays hidden until the write that would finish a command, because the decoder shows nothing between pulses. The bench therefore follows each disturbing stimulus with a full or partial sequence. The presence, absence or op code of the next pulse then exposes the step that was reached, two clocks after that write ends. A capture error in the front stage shows up as a wrong address or data byte on the program pulse. A failure to arm or disarm shows up as an extra pulse, or a missing one, on the write that follows.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    OP_RESET        = 3'd0,
    OP_AUTOSEL      = 3'd1,
    OP_PROGRAM      = 3'd2,
    OP_CHIP_ERASE   = 3'd3,
    OP_SECTOR_ERASE = 3'd4,
    OP_SUSPEND      = 3'd5,
    OP_RESUME       = 3'd6
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_PGM,
    ST_ERA0,
    ST_ERA1,
    ST_ERA2
  } step_e;

  // data byte codes, indexed by the constants below
  localparam int NCODE = 9;
  localparam int IX_KEY_A   = 0;
  localparam int IX_KEY_B   = 1;
  localparam int IX_RESET   = 2;
  localparam int IX_AUTOSEL = 3;
  localparam int IX_PGM     = 4;
  localparam int IX_ERASE   = 5;
  localparam int IX_CHIP    = 6;
  localparam int IX_SECT    = 7;
  localparam int IX_SUSP    = 8;

  localparam logic [DATA_W-1:0] CODE_LIST [NCODE] = '{
    8'hAA, 8'h55, 8'hF0, 8'h90, 8'hA0, 8'h80, 8'h10, 8'h30, 8'hB0
  };

  typedef struct packed {
    logic at_key_a;
    logic at_key_b;
    logic [NCODE-1:0] code_hit;
  } match_t;

endpackage

// File: rtl/fcd_bus_sampler.sv
module fcd_bus_sampler
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              inhibit,
  output logic              ev_valid,
  output logic [ADDR_W-1:0] ev_addr,
  output logic [DATA_W-1:0] ev_data
);

  logic wr_cond;
  logic released;
  logic armed;
  logic active;
  logic prev_active;

  assign released = ce_n | we_n;
  assign wr_cond  = ~ce_n & ~we_n & oe_n;
  assign active   = armed & wr_cond & ~inhibit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed       <= 1'b0;
      prev_active <= 1'b0;
      ev_valid    <= 1'b0;
      ev_addr     <= '0;
      ev_data     <= '0;
    end else begin
      prev_active <= active;
      ev_valid    <= prev_active & ~active & released & ~inhibit;
      // arming needs a released pin; output enable falling mid-window disarms
      if (inhibit)
        armed <= 1'b0;
      else if (released)
        armed <= 1'b1;
      else if (prev_active & ~wr_cond)
        armed <= 1'b0;
      if (active & ~prev_active)
        ev_addr <= addr;
      if (active)
        ev_data <= data_in;
    end
  end

  // R14: write events are at least two clocks apart
  p_event_gap_r14: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> !ev_valid);

  // R2: an event follows a clock where the window was closed by ce/we
  p_window_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> $past(released));

endmodule

// File: rtl/fcd_pattern_match.sv
module fcd_pattern_match
  import fcd_pkg::*;
#(
  parameter int              KEY_W = 15,
  parameter logic [KEY_W-1:0] KEY_A = 15'h5555,
  parameter logic [KEY_W-1:0] KEY_B = 15'h2AAA
) (
  input  logic [KEY_W-1:0]  key_addr,
  input  logic [DATA_W-1:0] ev_data,
  output match_t            m
);

  logic [NCODE-1:0] hit;

  for (genvar i = 0; i < NCODE; i++) begin : g_code
    assign hit[i] = (ev_data == CODE_LIST[i]);
  end

  always_comb begin
    m.at_key_a = (key_addr == KEY_A);
    m.at_key_b = (key_addr == KEY_B);
    m.code_hit = hit;
  end

  // R5: data matches at most one code
  always_comb begin
    a_code_unique_r5: assert ($onehot0(hit));
  end

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inhibit,
  input  logic              erase_active,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [DATA_W-1:0] ev_data,
  input  match_t            m,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic [SECT_W-1:0] cmd_sector
);

  step_e st, nxt;
  logic  fire;
  op_e   op;
  logic  key1, key2;

  assign key1 = m.at_key_a & m.code_hit[IX_KEY_A];
  assign key2 = m.at_key_b & m.code_hit[IX_KEY_B];

  always_comb begin
    nxt  = st;
    fire = 1'b0;
    op   = OP_RESET;
    if (ev_valid) begin
      nxt = ST_IDLE;
      if (st == ST_PGM) begin
        fire = 1'b1;
        op   = OP_PROGRAM;
      end else if (m.code_hit[IX_RESET]) begin
        fire = 1'b1;
        op   = OP_RESET;
      end else begin
        case (st)
          ST_IDLE: begin
            if (erase_active && m.code_hit[IX_SUSP]) begin
              fire = 1'b1;
              op   = OP_SUSPEND;
            end else if (erase_active && m.code_hit[IX_SECT]) begin
              fire = 1'b1;
              op   = OP_RESUME;
            end else if (key1) begin
              nxt = ST_UNL1;
            end
          end
          ST_UNL1: if (key2) nxt = ST_UNL2;
          ST_UNL2: begin
            if (m.at_key_a) begin
              if (m.code_hit[IX_AUTOSEL]) begin
                fire = 1'b1;
                op   = OP_AUTOSEL;
              end else if (m.code_hit[IX_PGM]) begin
                nxt = ST_PGM;
              end else if (m.code_hit[IX_ERASE]) begin
                nxt = ST_ERA0;
              end
            end
          end
          ST_ERA0: if (key1) nxt = ST_ERA1;
          ST_ERA1: if (key2) nxt = ST_ERA2;
          ST_ERA2: begin
            if (m.at_key_a && m.code_hit[IX_CHIP]) begin
              fire = 1'b1;
              op   = OP_CHIP_ERASE;
            end else if (m.code_hit[IX_SECT]) begin
              fire = 1'b1;
              op   = OP_SECTOR_ERASE;
            end
          end
          default: nxt = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cmd_valid  <= 1'b0;
      cmd_op     <= OP_RESET;
      cmd_addr   <= '0;
      cmd_data   <= '0;
      cmd_sector <= '0;
    end else if (inhibit) begin
      st        <= ST_IDLE;
      cmd_valid <= 1'b0;
    end else begin
      st        <= nxt;
      cmd_valid <= fire;
      if (fire) begin
        cmd_op     <= op;
        cmd_addr   <= ev_addr;
        cmd_data   <= ev_data;
        cmd_sector <= ev_addr[ADDR_W-1 -: SECT_W];
      end
    end
  end

  // R14: command pulse lasts one clock
  p_pulse_single_r14: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R12: inhibit leaves no command and the first step behind it
  p_inhibit_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> (!cmd_valid && st == ST_IDLE));

  // R11: every command stems from a write event
  p_cmd_from_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(ev_valid));

  // R6: program data step is only entered from the command step
  p_pgm_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PGM && $past(st) != ST_PGM) |-> $past(st) == ST_UNL2);

  // R7: final erase step is reached only through the second unlock
  p_erase_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERA2 && $past(st) != ST_ERA2) |-> $past(st) == ST_ERA1);

  // R5: op code stays inside the defined set
  p_op_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_op <= 3'd6);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int SECT_W = 3,
  parameter int KEY_W  = 15,
  parameter logic [KEY_W-1:0] KEY_A = 15'h5555,
  parameter logic [KEY_W-1:0] KEY_B = 15'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data_in,
  input  logic              inhibit,
  input  logic              erase_active,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data,
  output logic [SECT_W-1:0] cmd_sector
);

  logic              ev_valid;
  logic [ADDR_W-1:0] ev_addr;
  logic [DATA_W-1:0] ev_data;
  match_t            m;

  fcd_bus_sampler #(.ADDR_W(ADDR_W)) u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .addr     (addr),
    .data_in  (data_in),
    .inhibit  (inhibit),
    .ev_valid (ev_valid),
    .ev_addr  (ev_addr),
    .ev_data  (ev_data)
  );

  fcd_pattern_match #(.KEY_W(KEY_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_match (
    .key_addr (ev_addr[KEY_W-1:0]),
    .ev_data  (ev_data),
    .m        (m)
  );

  fcd_seq_fsm #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .inhibit      (inhibit),
    .erase_active (erase_active),
    .ev_valid     (ev_valid),
    .ev_addr      (ev_addr),
    .ev_data      (ev_data),
    .m            (m),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_addr     (cmd_addr),
    .cmd_data     (cmd_data),
    .cmd_sector   (cmd_sector)
  );

  // R12: no command pulse in the clock after inhibit, across both stages
  p_inhibit_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> !cmd_valid);

endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n, we_n, oe_n;
  logic [18:0] addr;
  logic [7:0]  din;
  logic        inhibit, erase_active;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [18:0] cmd_addr;
  logic [7:0]  cmd_data;
  logic [2:0]  cmd_sector;

  always #4 clk = ~clk;

  flash_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .data_in(din), .inhibit(inhibit), .erase_active(erase_active),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_sector(cmd_sector)
  );

  int n_chk = 0, n_fail = 0;
  int n_pulse = 0, base = 0, wide = 0;
  int l_op = 0, l_addr = 0, l_data = 0, l_sec = 0;
  bit prev_cv = 1'b0;

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (cmd_valid) begin
        n_pulse++;
        l_op = int'(cmd_op); l_addr = int'(cmd_addr);
        l_data = int'(cmd_data); l_sec = int'(cmd_sector);
        if (prev_cv) wide++;
      end
      prev_cv = cmd_valid;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    chk(wide == 0, "R14 pulse width", wide, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  function automatic logic [18:0] mk(input int hi, input logic [14:0] lo);
    return {4'(hi), lo};
  endfunction

  task automatic mark(); base = n_pulse; endtask

  task automatic wr_pins(input logic [18:0] a, input logic [7:0] d,
                         input logic c, input logic w, input logic o);
    @(negedge clk); addr = a; din = d; ce_n = c; we_n = w; oe_n = o;
    @(negedge clk); @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    wr_pins(a, d, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic unlock(input int hi);
    wr(mk(hi, 15'h5555), 8'hAA);
    wr(mk(hi, 15'h2AAA), 8'h55);
  endtask

  task automatic expect_none(input string req);
    chk(n_pulse == base, req, n_pulse - base, 0);
  endtask

  task automatic expect_cmd(input string req, input int op, input int a, input int d);
    chk(n_pulse == base + 1, req, n_pulse - base, 1);
    chk(l_op == op, req, l_op, op);
    if (a >= 0) chk(l_addr == a, req, l_addr, a);
    if (d >= 0) chk(l_data == d, req, l_data, d);
  endtask

  initial begin
    rst_n = 1'b0; inhibit = 1'b0; erase_active = 1'b0;
    // R13: write pins already low through reset release
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = mk(0, 15'h5555); din = 8'hF0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cmd_valid == 1'b0, "R1 reset output", int'(cmd_valid), 0);
    mark();
    ce_n = 1'b1; we_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_none("R13 power-up write");

    // R1/R6: program with no preceding reset command
    mark(); unlock(0); wr(mk(0, 15'h5555), 8'hA0); wr(19'h12345, 8'h3C);
    expect_cmd("R1 program", 2, 'h12345, 'h3C);
    chk(l_sec == 1, "R8 sector of program", l_sec, 1);

    // R14: exact pulse timing
    @(negedge clk); addr = 19'h0; din = 8'hF0; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk); chk(cmd_valid == 1'b0, "R14 edge1", int'(cmd_valid), 0);
    @(negedge clk); chk(cmd_valid == 1'b1, "R14 edge2", int'(cmd_valid), 1);
    @(negedge clk); chk(cmd_valid == 1'b0, "R14 after", int'(cmd_valid), 0);

    // R4: upper address bits ignored for keys
    for (int hi = 0; hi < 16; hi++) begin
      mark();
      wr(mk(hi, 15'h5555), 8'hAA);
      wr(mk(hi ^ 5, 15'h2AAA), 8'h55);
      wr(mk(hi ^ 3, 15'h5555), 8'h90);
      expect_cmd("R4 autoselect", 1, int'(mk(hi ^ 3, 15'h5555)), 'h90);
    end

    // R5/R6/R9: sweep every third byte, then a reset byte
    for (int d = 0; d < 256; d++) begin
      mark(); unlock(d & 15); wr(mk(0, 15'h5555), 8'(d));
      if (d == 'h90) expect_cmd("R5 autoselect", 1, -1, 'h90);
      else if (d == 'hF0) expect_cmd("R9 reset third", 0, -1, 'hF0);
      else expect_none("R5 third byte");
      mark(); wr(19'h0, 8'hF0);
      if (d == 'hA0) expect_cmd("R6 program F0 data", 2, 0, 'hF0);
      else expect_cmd("R9 reset", 0, 0, 'hF0);
    end

    // R3: address from window start, data from its last clock
    unlock(0); wr(mk(0, 15'h5555), 8'hA0);
    mark();
    @(negedge clk); addr = 19'h4ABCD; din = 8'h11; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); addr = 19'h00FFF; din = 8'h77;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_cmd("R3 capture", 2, 'h4ABCD, 'h77);

    // R7: chip erase, and 10h off the key address
    mark(); unlock(2); wr(mk(1, 15'h5555), 8'h80); unlock(9); wr(mk(7, 15'h5555), 8'h10);
    expect_cmd("R7 chip erase", 3, -1, 'h10);
    mark(); unlock(0); wr(mk(0, 15'h5555), 8'h80); unlock(0); wr(19'h01234, 8'h10);
    expect_none("R7 misplaced 10h");

    // R8: sector erase in every sector
    for (int s = 0; s < 8; s++) begin
      mark(); unlock(0); wr(mk(0, 15'h5555), 8'h80); unlock(0);
      wr({3'(s), 16'(s * 9029)}, 8'h30);
      expect_cmd("R8 sector erase", 4, int'({3'(s), 16'(s * 9029)}), 'h30);
      chk(l_sec == s, "R8 sector index", l_sec, s);
    end

    // R9: reset byte mid-sequence, then stale step must be gone
    mark(); unlock(0); wr(19'h3BEEF, 8'hF0);
    expect_cmd("R9 mid reset", 0, 'h3BEEF, 'hF0);
    mark(); wr(mk(0, 15'h5555), 8'h90); expect_none("R9 back to start");
    mark(); unlock(0); wr(mk(0, 15'h5555), 8'h80); wr(mk(0, 15'h5555), 8'hAA);
    wr(19'h7, 8'hF0); expect_cmd("R9 reset in erase", 0, 7, 'hF0);

    // R10: suspend and resume
    erase_active = 1'b1;
    mark(); wr(19'h50777, 8'hB0); expect_cmd("R10 suspend", 5, 'h50777, 'hB0);
    mark(); wr(19'h00001, 8'h30); expect_cmd("R10 resume", 6, 1, 'h30);
    erase_active = 1'b0;
    mark(); wr(19'h1, 8'hB0); wr(19'h1, 8'h30); expect_none("R10 idle engine");

    // R11: mismatches restart without reuse
    mark(); wr(mk(0, 15'h5555), 8'hAA); wr(mk(0, 15'h5555), 8'hAA);
    wr(mk(0, 15'h2AAA), 8'h55); wr(mk(0, 15'h5555), 8'h90);
    expect_none("R11 repeated first key");
    mark(); wr(mk(0, 15'h5555), 8'hAA); wr(mk(0, 15'h2AAB), 8'h55);
    wr(mk(0, 15'h5555), 8'h90); expect_none("R11 wrong key address");

    // R2: blocked write forms
    mark(); wr(mk(0, 15'h5555), 8'hAA);
    wr_pins(mk(0, 15'h2AAA), 8'h55, 1'b0, 1'b0, 1'b0);
    wr(mk(0, 15'h2AAA), 8'h55); wr(mk(0, 15'h5555), 8'h90);
    expect_cmd("R2 oe low ignored", 1, -1, 'h90);
    mark(); wr(mk(0, 15'h5555), 8'hAA);
    wr_pins(mk(0, 15'h2AAA), 8'h55, 1'b1, 1'b0, 1'b1);
    wr(mk(0, 15'h2AAA), 8'h55); wr(mk(0, 15'h5555), 8'h90);
    expect_cmd("R2 ce high ignored", 1, -1, 'h90);
    mark(); wr(mk(0, 15'h5555), 8'hAA);
    @(negedge clk); addr = mk(0, 15'h2AAA); din = 8'h55; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); oe_n = 1'b0;
    @(negedge clk); oe_n = 1'b1;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    repeat (3) @(negedge clk);
    wr(mk(0, 15'h2AAA), 8'h55); wr(mk(0, 15'h5555), 8'h90);
    expect_cmd("R2 aborted window", 1, -1, 'h90);

    // R12: inhibit blocks writes and clears the sequence
    mark(); inhibit = 1'b1; wr(19'h0, 8'hF0); inhibit = 1'b0;
    expect_none("R12 write blocked");
    mark(); unlock(0);
    inhibit = 1'b1; repeat (3) @(negedge clk); inhibit = 1'b0;
    wr(mk(0, 15'h5555), 8'h90); expect_none("R12 sequence cleared");

    finish_up();
  end

endmodule